// File: doc/BRIEF.md
# Cascadable Codec Channel Serial Port

This block is the serial-port controller of one channel in a chain of codec channels that share a single serial link to a host processor. Words are 16 bits long and travel MSB first on a data line paired with a frame-sync line. Each channel receives words from its upstream neighbour and drives words to its downstream neighbour. The last channel in the chain feeds the host, and the host feeds the first channel. On every sampling event the channel loads its own ADC sample and starts sending it downstream.

The channel has two addressing schemes on the same serial path. In program mode, a word with its flag bit set is a control word. If its address field is zero, the channel keeps it and writes one of its three control registers. If the address is non-zero, the channel lowers the address by one and passes the word on. Words with the flag clear, such as ADC samples from further up the chain, pass through unchanged. In data mode, which is entered by a write to register A, the address inside each word no longer matters. The channel counts received frames against the cascade length held in register A. It forwards every word before the count is reached, keeps the word that reaches it as its DAC sample, and then starts the count again.

The serial lines carry no valid/ready handshake and there is no back-pressure. The frame sync alone marks the start of a word. A transmit request that arrives while a word is still being sent is dropped. A sampling event takes priority over a word waiting to be forwarded in the same cycle. All logic runs on the serial clock.

Top module: `cascade_sport`

## Requirements
- R1: After reset, sdo and sdo_fs are low, ctrl_a, ctrl_b, ctrl_c and dac_word are zero, and the channel is in program mode (data_mode low, cascade_len zero).
- R2: A sample_stb high in one cycle makes sdo_fs high in the next cycle for exactly one cycle. The 16 bits of adc_word follow on sdo, MSB first, one per cycle, and sdo is low whenever no word is being sent.
- R3: A word is received as sdi_fs high for one cycle followed by 16 bits on sdi, MSB first. Its fields are: bit 15 the control flag, bits 14:12 the address, bits 11:9 the register select, bits 7:0 the data. In program mode, a word with the flag set, address 0 and select 0, 1 or 2 writes its data into ctrl_a, ctrl_b or ctrl_c respectively, and it is not sent on.
- R4: In program mode, a word with the flag set and a non-zero address is sent on sdo with the address field lowered by one and all other bits unchanged. No register changes.
- R5: In program mode, a word with the flag clear is sent on sdo unchanged.
- R6: In program mode, a word with the flag set, address 0 and a select value of 3 to 7 changes no register and is not sent on.
- R7: In register A, bit 0 is the mode bit (1 = data mode) and bits 3:1 are the cascade length, seen on data_mode and cascade_len. Once data_mode is set it stays set until reset, and words with the flag set are then treated as data.
- R8: In data mode, with cascade length N of 2 or more, the first N-1 words received after entering data mode, or after the last DAC update, are sent on unchanged. The Nth word is loaded into dac_word, is not sent on, and restarts the count. ctrl_a, ctrl_b and ctrl_c do not change in data mode, and dac_word does not change in program mode.
- R9: A transmit request, whether a sampling event or a word to forward, that arrives while a word is still being sent is dropped. The word in progress is not disturbed.
- R10: In data mode, a cascade length of 0 or 1 loads every received word into dac_word and sends none of them on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi | input | 1 | Serial data from upstream, MSB first |
| sdi_fs | input | 1 | Input frame sync, one cycle before the first bit |
| sample_stb | input | 1 | Sampling-event strobe, one cycle |
| adc_word | input | 16 | ADC sample loaded at a sampling event |
| sdo | output | 1 | Serial data to downstream, MSB first |
| sdo_fs | output | 1 | Output frame sync, one cycle before the first bit |
| dac_word | output | 16 | DAC register |
| ctrl_a | output | 8 | Control register A (mode bit, cascade length) |
| ctrl_b | output | 8 | Control register B (bits 1:0 master divider, 3:2 serial clock rate, 6:4 sample rate) |
| ctrl_c | output | 8 | Control register C (bit 0 ADC, bit 1 DAC, bit 2 reference power-up) |
| data_mode | output | 1 | High once data mode is entered |
| cascade_len | output | 3 | Cascade length from register A |

## Verification
A receive bit counter that slips by one shifts every later field. A forwarded word then comes out with its address, select or data moved by one bit, which the host sees on sdo about 34 cycles after the frame started. A decode error in program mode shows at once as a wrong control register, or as a word that appears on sdo when it should not, or fails to appear when it should. A frame counter that does not restart puts the wrong word in dac_word within one cascade cycle and forwards a word that should have been kept. A transmitter that accepts a request while busy produces a second frame sync fewer than 17 cycles after the first.

// File: rtl/cascade_sport_pkg.sv
package cascade_sport_pkg;

  // Register select codes carried in a control word
  localparam int REG_SEL_A = 0;
  localparam int REG_SEL_B = 1;
  localparam int REG_SEL_C = 2;
  localparam int NUM_REGS  = 3;

  // Register A field positions
  localparam int MODE_BIT = 0;
  localparam int LEN_LO   = 1;

  // What the transmitter is loaded with in a given cycle
  typedef enum logic [1:0] {
    TX_NONE = 2'd0,
    TX_ADC  = 2'd1,
    TX_FWD  = 2'd2
  } tx_src_e;

endpackage

// File: rtl/cascade_sport_rx.sv
module cascade_sport_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              sdi_fs,
  output logic              word_done,
  output logic [WORD_W-1:0] word
);
  localparam int CW = $clog2(WORD_W + 1);

  logic [CW-1:0] bits_left;

  // Frame sync is taken only when idle; bits then shift in MSB first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_left <= '0;
      word      <= '0;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (bits_left == '0) begin
        if (sdi_fs) bits_left <= CW'(WORD_W);
      end else begin
        word      <= {word[WORD_W-2:0], sdi};
        bits_left <= bits_left - 1'b1;
        if (bits_left == CW'(1)) word_done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cascade_sport_tx.sv
module cascade_sport_tx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] load_word,
  output logic              ready,
  output logic              sdo,
  output logic              sdo_fs
);
  localparam int CW = $clog2(WORD_W + 1);

  logic              fs_q;
  logic [CW-1:0]     bits_left;
  logic [WORD_W-1:0] shreg;

  // Ready while idle or while the last bit is on the line
  assign ready  = !fs_q && (bits_left <= CW'(1));
  assign sdo_fs = fs_q;
  assign sdo    = (!fs_q && bits_left != '0) ? shreg[WORD_W-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q      <= 1'b0;
      bits_left <= '0;
      shreg     <= '0;
    end else if (start && ready) begin
      fs_q      <= 1'b1;
      shreg     <= load_word;
      bits_left <= CW'(WORD_W);
    end else if (fs_q) begin
      fs_q <= 1'b0;
    end else if (bits_left != '0) begin
      shreg     <= {shreg[WORD_W-2:0], 1'b0};
      bits_left <= bits_left - 1'b1;
    end
  end
endmodule

// File: rtl/cascade_sport_ctrl.sv
module cascade_sport_ctrl
  import cascade_sport_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 3,
  parameter int SEL_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              sample_stb,
  input  logic [WORD_W-1:0] adc_word,
  input  logic              tx_ready,
  output logic              tx_start,
  output logic [WORD_W-1:0] tx_word,
  output logic [WORD_W-1:0] dac_word,
  output logic [DATA_W-1:0] reg_a,
  output logic [DATA_W-1:0] reg_b,
  output logic [DATA_W-1:0] reg_c
);
  localparam int FLAG_BIT = WORD_W - 1;
  localparam int ADDR_HI  = FLAG_BIT - 1;
  localparam int ADDR_LO  = FLAG_BIT - ADDR_W;
  localparam int SEL_HI   = ADDR_LO - 1;
  localparam int SEL_LO   = ADDR_LO - SEL_W;
  localparam int LEN_HI   = LEN_LO + ADDR_W - 1;

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [ADDR_W-1:0] fcount;
  logic [ADDR_W:0]   fcount_inc;
  logic [ADDR_W-1:0] addr;
  logic [SEL_W-1:0]  sel;
  logic              is_ctrl;
  logic              in_data;
  logic [ADDR_W-1:0] cas_len;
  logic              wr_own;
  logic              dac_hit;
  logic              fwd_req;
  logic [WORD_W-1:0] fwd_word;
  tx_src_e           src;

  assign is_ctrl    = rx_word[FLAG_BIT];
  assign addr       = rx_word[ADDR_HI:ADDR_LO];
  assign sel        = rx_word[SEL_HI:SEL_LO];
  assign in_data    = regs[REG_SEL_A][MODE_BIT];
  assign cas_len    = regs[REG_SEL_A][LEN_HI:LEN_LO];
  assign fcount_inc = {1'b0, fcount} + 1'b1;

  // Routing decision for a completed received word
  always_comb begin
    wr_own   = 1'b0;
    dac_hit  = 1'b0;
    fwd_req  = 1'b0;
    fwd_word = rx_word;
    if (rx_done) begin
      if (in_data) begin
        if (fcount_inc >= {1'b0, cas_len}) dac_hit = 1'b1;
        else                               fwd_req = 1'b1;
      end else if (is_ctrl && addr == '0) begin
        wr_own = 1'b1;
      end else if (is_ctrl) begin
        fwd_req                   = 1'b1;
        fwd_word[ADDR_HI:ADDR_LO] = addr - 1'b1;
      end else begin
        fwd_req = 1'b1;
      end
    end
  end

  // Sampling event wins over forwarding; transmitter busy drops both
  always_comb begin
    if (!tx_ready)       src = TX_NONE;
    else if (sample_stb) src = TX_ADC;
    else if (fwd_req)    src = TX_FWD;
    else                 src = TX_NONE;
  end

  assign tx_start = (src != TX_NONE);
  assign tx_word  = (src == TX_ADC) ? adc_word : fwd_word;

  // One register per select code
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           regs[g] <= '0;
      else if (wr_own && sel == SEL_W'(g))  regs[g] <= rx_word[DATA_W-1:0];
    end
  end

  assign reg_a = regs[REG_SEL_A];
  assign reg_b = regs[REG_SEL_B];
  assign reg_c = regs[REG_SEL_C];

  // Frame counting and DAC update in data mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcount   <= '0;
      dac_word <= '0;
    end else if (rx_done && in_data) begin
      if (dac_hit) begin
        dac_word <= rx_word;
        fcount   <= '0;
      end else begin
        fcount <= fcount_inc[ADDR_W-1:0];
      end
    end
  end
endmodule

// File: rtl/cascade_sport.sv
module cascade_sport
  import cascade_sport_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 3,
  parameter int SEL_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              sdi_fs,
  input  logic              sample_stb,
  input  logic [WORD_W-1:0] adc_word,
  output logic              sdo,
  output logic              sdo_fs,
  output logic [WORD_W-1:0] dac_word,
  output logic [DATA_W-1:0] ctrl_a,
  output logic [DATA_W-1:0] ctrl_b,
  output logic [DATA_W-1:0] ctrl_c,
  output logic              data_mode,
  output logic [ADDR_W-1:0] cascade_len
);
  logic              rx_done;
  logic [WORD_W-1:0] rx_word;
  logic              tx_start;
  logic              tx_ready;
  logic [WORD_W-1:0] tx_word;

  cascade_sport_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .sdi_fs(sdi_fs),
    .word_done(rx_done), .word(rx_word)
  );

  cascade_sport_ctrl #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_word(rx_word),
    .sample_stb(sample_stb), .adc_word(adc_word), .tx_ready(tx_ready),
    .tx_start(tx_start), .tx_word(tx_word), .dac_word(dac_word),
    .reg_a(ctrl_a), .reg_b(ctrl_b), .reg_c(ctrl_c)
  );

  cascade_sport_tx #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .load_word(tx_word),
    .ready(tx_ready), .sdo(sdo), .sdo_fs(sdo_fs)
  );

  assign data_mode   = ctrl_a[MODE_BIT];
  assign cascade_len = ctrl_a[LEN_LO+ADDR_W-1:LEN_LO];
endmodule

// File: rtl/cascade_sport_chk.sv
module cascade_sport_chk #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sdo,
  input logic              sdo_fs,
  input logic [WORD_W-1:0] dac_word,
  input logic [DATA_W-1:0] ctrl_a,
  input logic [DATA_W-1:0] ctrl_b,
  input logic [DATA_W-1:0] ctrl_c,
  input logic              data_mode
);
  localparam int CW = $clog2(WORD_W + 1);

  // Cycles left in the bit window of the last frame seen on sdo
  logic [CW-1:0] win;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          win <= '0;
    else if (sdo_fs)     win <= CW'(WORD_W);
    else if (win != '0)  win <= win - 1'b1;
  end

  // R9: no new frame sync before the previous word has fully left
  assert_no_early_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_fs |-> (win == '0));

  // R2: data line idle outside a bit window
  assert_idle_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (win == '0) |-> !sdo);

  // R7: data mode is sticky
  assert_mode_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    data_mode |=> data_mode);

  // R8: DAC register holds in program mode
  assert_dac_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !data_mode |=> $stable(dac_word));

  // R8: control registers frozen in data mode
  assert_regs_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_mode |=> ($stable(ctrl_a) && $stable(ctrl_b) && $stable(ctrl_c)));
endmodule

bind cascade_sport cascade_sport_chk #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sdo(sdo), .sdo_fs(sdo_fs),
  .dac_word(dac_word), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b),
  .ctrl_c(ctrl_c), .data_mode(data_mode)
);

// File: tb/test_cascade_sport.sv
module test_cascade_sport;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sdi = 1'b0;
  logic        sdi_fs = 1'b0;
  logic        sample_stb = 1'b0;
  logic [15:0] adc_word = '0;
  logic        sdo, sdo_fs;
  logic [15:0] dac_word;
  logic [7:0]  ctrl_a, ctrl_b, ctrl_c;
  logic        data_mode;
  logic [2:0]  cascade_len;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cascade_sport i_cascade_sport (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .sdi_fs(sdi_fs),
    .sample_stb(sample_stb), .adc_word(adc_word), .sdo(sdo), .sdo_fs(sdo_fs),
    .dac_word(dac_word), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .ctrl_c(ctrl_c),
    .data_mode(data_mode), .cascade_len(cascade_len)
  );

  // Output monitor: collects every word seen on sdo
  logic [15:0] mon_q [64];
  int          mon_n = 0;
  int          mcnt = 0;
  logic [15:0] msh = '0;
  always @(negedge clk) begin
    if (sdo_fs) mcnt = 16;
    else if (mcnt > 0) begin
      msh  = {msh[14:0], sdo};
      mcnt = mcnt - 1;
      if (mcnt == 0 && mon_n < 64) begin
        mon_q[mon_n] = msh;
        mon_n = mon_n + 1;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sdi = 1'b0; sdi_fs = 1'b0; sample_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_word(input logic [15:0] w);
    @(negedge clk);
    sdi_fs = 1'b1; sdi = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      sdi_fs = 1'b0; sdi = w[i];
    end
  endtask

  task automatic settle(input int n);
    @(negedge clk);
    sdi = 1'b0; sdi_fs = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "sdo_fs", sdo_fs, 0);
    chk("R1", "sdo", sdo, 0);
    chk("R1", "regs", {ctrl_a, ctrl_b, ctrl_c}, 0);
    chk("R1", "dac", dac_word, 0);
    chk("R1", "mode/len", {data_mode, cascade_len}, 0);
  endtask

  task automatic t_sample();
    int n0;
    n0 = mon_n;
    @(negedge clk);
    adc_word = 16'hA5C3; sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    chk("R2", "fs next cycle", sdo_fs, 1);
    @(negedge clk);
    chk("R2", "fs one cycle", sdo_fs, 0);
    settle(20);
    chk("R2", "word count", mon_n - n0, 1);
    chk("R2", "adc word", mon_q[n0], 16'hA5C3);
  endtask

  task automatic t_own_write();
    int n0;
    n0 = mon_n;
    send_word(16'h825A);
    send_word(16'h8407);
    settle(25);
    chk("R3", "ctrl_b", ctrl_b, 8'h5A);
    chk("R3", "ctrl_c", ctrl_c, 8'h07);
    chk("R3", "ctrl_a", ctrl_a, 8'h00);
    chk("R3", "not forwarded", mon_n - n0, 0);
  endtask

  task automatic t_forward();
    int n0;
    n0 = mon_n;
    send_word(16'hB011);
    settle(25);
    chk("R4", "count addr3", mon_n - n0, 1);
    chk("R4", "addr3 decremented", mon_q[n0], 16'hA011);
    send_word(16'h9233);
    settle(25);
    chk("R4", "addr1 decremented", mon_q[n0+1], 16'h8233);
    chk("R4", "regs untouched", {ctrl_a, ctrl_b}, {8'h00, 8'h5A});
    send_word(16'h1234);
    settle(25);
    chk("R5", "count", mon_n - n0, 3);
    chk("R5", "unchanged", mon_q[n0+2], 16'h1234);
  endtask

  task automatic t_bad_sel();
    int n0;
    n0 = mon_n;
    send_word(16'h8A77);
    send_word(16'h8E11);
    settle(25);
    chk("R6", "regs", {ctrl_a, ctrl_b, ctrl_c}, {8'h00, 8'h5A, 8'h07});
    chk("R6", "not forwarded", mon_n - n0, 0);
  endtask

  task automatic t_busy();
    int n0;
    n0 = mon_n;
    @(negedge clk);
    adc_word = 16'h1357; sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    repeat (4) @(negedge clk);
    adc_word = 16'h2468; sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    settle(30);
    chk("R9", "one word", mon_n - n0, 1);
    chk("R9", "first kept", mon_q[n0], 16'h1357);
  endtask

  task automatic t_data_mode();
    int n0;
    send_word(16'h8005);
    settle(3);
    chk("R7", "data_mode", data_mode, 1);
    chk("R7", "cascade_len", cascade_len, 2);
    n0 = mon_n;
    send_word(16'h8003);
    send_word(16'h2222);
    settle(25);
    chk("R7", "flagged word as data", mon_q[n0], 16'h8003);
    chk("R7", "regs unchanged", ctrl_a, 8'h05);
    chk("R8", "first forwarded only", mon_n - n0, 1);
    chk("R8", "dac second word", dac_word, 16'h2222);
    send_word(16'h3333);
    send_word(16'h4444);
    settle(25);
    chk("R8", "restart count", mon_n - n0, 2);
    chk("R8", "forward after restart", mon_q[n0+1], 16'h3333);
    chk("R8", "dac after restart", dac_word, 16'h4444);
    chk("R8", "regs frozen", {ctrl_b, ctrl_c}, {8'h5A, 8'h07});
  endtask

  task automatic t_len_one();
    int n0;
    do_reset();
    chk("R1", "dac after reset", dac_word, 0);
    chk("R1", "mode after reset", data_mode, 0);
    send_word(16'h8003);
    settle(3);
    n0 = mon_n;
    send_word(16'h7777);
    settle(25);
    chk("R10", "dac len1", dac_word, 16'h7777);
    chk("R10", "none forwarded", mon_n - n0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset();
    t_sample();
    t_own_write();
    t_forward();
    t_bad_sel();
    t_busy();
    t_data_mode();
    t_len_one();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule